// File: doc/BRIEF.md
# USB Link State Path Controller

This block is the bus-monitor state machine of a USB 2.0 repeater that sits between a host-side (internal) port and a device-side (external) port. It watches the decoded line state of each port and follows the high-speed detection handshake. From what it sees, it picks the signal path: either the direct full/low-speed bypass switch or the high-speed resynchronizer. No software is involved in switching. The block follows the host's chirp train after a bus reset and moves to the resynchronizer when the train ends. It returns to bypass when a long SE0 shows that frame markers have stopped, as happens during a host/device role swap.

The block also recognises high-speed Test J and Test K on either port. It then latches a forwarding mode that asks the opposite port's transmitter to hold the same level. Only a low enable or the asynchronous reset clears this mode. A low enable otherwise parks the block in a disconnect state, and the ports stay joined through the bypass switch.

Top module: `usb_lsp_ctrl`

## Requirements
- R1: After reset with `en_i` high, `state_o` is 1 (full/low-speed), `path_hs_o` and `resync_en_o` are 0, and neither drive request is raised. The state codes are 0 disconnect, 1 full/low-speed, 2 chirp, 3 high-speed and 4 test-forward.
- R2: The line codes on `int_line_i`/`ext_line_i` are 0 SE0, 1 J, 2 K and 3 SE1. In state 1, a K sampled on the internal port moves the block to state 2.
- R3: In state 2, an SE0 on the internal port moves the block to state 3, provided at least MIN_PAIRS K-then-J pairs were sampled there. `path_hs_o` and `resync_en_o` rise on that same clock edge, well inside any few-microsecond budget.
- R4: In state 2, an SE0 on the internal port after fewer than MIN_PAIRS K-then-J pairs returns the block to state 1, with the bypass path kept.
- R5: In state 3, SE0 on both ports for SE0_CYC consecutive sampled cycles returns the block to state 1 and drops `path_hs_o` and `resync_en_o`. Any other line state on either port restarts the count.
- R6: After a fall back from state 3 to state 1, a new valid chirp train brings the block back to state 3.
- R7: `en_i` low moves the block to state 0 on the next edge from any state, with `path_hs_o` and `resync_en_o` at 0 and no drive request. Activity on the lines is ignored there. `en_i` high again leads to state 1.
- R8: In state 3, an unchanging J or K on one port for TEST_CYC cycles after the first one moves the block to state 4. The block then raises the drive request of the opposite port (`drive_int_o` for a level seen on the external port, `drive_ext_o` for the internal one) with `drive_k_o` = 1 for K and 0 for J, and keeps `resync_en_o` at 1.
- R9: State 4 and its drive outputs ignore all later line activity, including a long SE0. Only `en_i` low or `rst_ni` low leaves it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Block enable; low forces the disconnect state |
| int_line_i | input | 2 | Decoded line state of the host-side port |
| ext_line_i | input | 2 | Decoded line state of the device-side port |
| path_hs_o | output | 1 | 1 selects the resynchronizer path, 0 the bypass switch |
| resync_en_o | output | 1 | Resynchronizer enable |
| drive_int_o | output | 1 | Request to drive the test level on the host-side port |
| drive_ext_o | output | 1 | Request to drive the test level on the device-side port |
| drive_k_o | output | 1 | Level to drive: 1 K, 0 J |
| state_o | output | 3 | Current state code |

## Verification
The hardest situation to reach from the ports is the latched test-forward mode, because it needs a completed chirp handshake first. After that the stimulus must hold a level that does not change for the full detection window, and the fall-back timer must not expire before it. The bench runs a complete chirp train and then drives an unchanging K on one port right away. It then confirms that both a burst of line activity and an SE0 longer than the fall-back window leave the mode and its drive outputs unchanged. Both edges of the SE0 window are exercised by stopping one cycle short, breaking the run with a J, and then completing it.

// File: rtl/usb_lsp_pkg.sv
package usb_lsp_pkg;
  typedef enum logic [1:0] {
    LINE_SE0 = 2'd0,
    LINE_J   = 2'd1,
    LINE_K   = 2'd2,
    LINE_SE1 = 2'd3
  } line_e;

  typedef enum logic [2:0] {
    ST_DISC  = 3'd0,
    ST_FSLS  = 3'd1,
    ST_CHIRP = 3'd2,
    ST_HS    = 3'd3,
    ST_TEST  = 3'd4
  } lsp_state_e;

  localparam int unsigned NUM_PORTS = 2;
  localparam int unsigned PORT_INT  = 0;
  localparam int unsigned PORT_EXT  = 1;
endpackage

// File: rtl/lsp_run_timer.sv
module lsp_run_timer #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic cond_i,
  output logic hit_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  // hit on the LIMIT-th consecutive sampled cycle of cond
  assign hit_o = !clr_i && cond_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clr_i || !cond_i) begin
      cnt_q <= '0;
    end else if (cnt_q != LAST) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/lsp_test_watch.sv
module lsp_test_watch
  import usb_lsp_pkg::*;
#(
  parameter int unsigned LIMIT = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic [1:0] line_i,
  output logic       hit_o,
  output logic       lvl_k_o
);
  line_e line, last_q;
  logic  steady;

  assign line    = line_e'(line_i);
  assign steady  = (line == LINE_J || line == LINE_K) && (line == last_q);
  assign lvl_k_o = (line == LINE_K);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= LINE_SE0;
    else         last_q <= line;
  end

  lsp_run_timer #(.LIMIT(LIMIT)) u_run (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr_i),
    .cond_i (steady),
    .hit_o  (hit_o)
  );
endmodule

// File: rtl/lsp_chirp_tracker.sv
module lsp_chirp_tracker
  import usb_lsp_pkg::*;
#(
  parameter int unsigned MIN_PAIRS = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic [1:0] line_i,
  output logic       enough_o
);
  localparam int unsigned PW = $clog2(MIN_PAIRS + 1);
  localparam logic [PW-1:0] PMAX = PW'(MIN_PAIRS);

  line_e         line, prev_q;
  logic [PW-1:0] pairs_q;
  logic          kj_edge;

  assign line     = line_e'(line_i);
  assign kj_edge  = (prev_q == LINE_K) && (line == LINE_J);
  assign enough_o = (pairs_q == PMAX);

  // prev tracks always so the entry K is seen before the count opens
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= LINE_SE0;
      pairs_q <= '0;
    end else begin
      prev_q <= line;
      if (clr_i)                          pairs_q <= '0;
      else if (kj_edge && pairs_q != PMAX) pairs_q <= pairs_q + 1'b1;
    end
  end
endmodule

// File: rtl/usb_lsp_ctrl.sv
module usb_lsp_ctrl
  import usb_lsp_pkg::*;
#(
  parameter int unsigned SE0_CYC   = 750000,
  parameter int unsigned TEST_CYC  = 2048,
  parameter int unsigned MIN_PAIRS = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic [1:0] int_line_i,
  input  logic [1:0] ext_line_i,
  output logic       path_hs_o,
  output logic       resync_en_o,
  output logic       drive_int_o,
  output logic       drive_ext_o,
  output logic       drive_k_o,
  output logic [2:0] state_o
);
  lsp_state_e state_q, state_d;
  logic       src_ext_q, src_ext_d;
  logic       lvl_k_q, lvl_k_d;
  logic       in_hs, chirp_ok, se0_both, se0_hit;

  logic [1:0] lines [NUM_PORTS];
  logic       test_hit [NUM_PORTS];
  logic       test_k   [NUM_PORTS];

  assign lines[PORT_INT] = int_line_i;
  assign lines[PORT_EXT] = ext_line_i;
  assign in_hs    = (state_q == ST_HS);
  assign se0_both = (line_e'(int_line_i) == LINE_SE0) && (line_e'(ext_line_i) == LINE_SE0);

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_watch
    lsp_test_watch #(.LIMIT(TEST_CYC)) u_watch (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (!in_hs),
      .line_i  (lines[p]),
      .hit_o   (test_hit[p]),
      .lvl_k_o (test_k[p])
    );
  end

  lsp_chirp_tracker #(.MIN_PAIRS(MIN_PAIRS)) u_chirp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (state_q != ST_CHIRP),
    .line_i   (int_line_i),
    .enough_o (chirp_ok)
  );

  lsp_run_timer #(.LIMIT(SE0_CYC)) u_se0 (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (!in_hs),
    .cond_i (se0_both),
    .hit_o  (se0_hit)
  );

  always_comb begin
    state_d   = state_q;
    src_ext_d = src_ext_q;
    lvl_k_d   = lvl_k_q;
    if (!en_i) begin
      state_d = ST_DISC;
    end else begin
      unique case (state_q)
        ST_DISC:  state_d = ST_FSLS;
        ST_FSLS:  if (line_e'(int_line_i) == LINE_K) state_d = ST_CHIRP;
        ST_CHIRP: if (line_e'(int_line_i) == LINE_SE0) state_d = chirp_ok ? ST_HS : ST_FSLS;
        ST_HS: begin
          if (test_hit[PORT_INT]) begin
            state_d   = ST_TEST;
            src_ext_d = 1'b0;
            lvl_k_d   = test_k[PORT_INT];
          end else if (test_hit[PORT_EXT]) begin
            state_d   = ST_TEST;
            src_ext_d = 1'b1;
            lvl_k_d   = test_k[PORT_EXT];
          end else if (se0_hit) begin
            state_d = ST_FSLS;
          end
        end
        ST_TEST:  state_d = ST_TEST;
        default:  state_d = ST_FSLS;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_FSLS;
      src_ext_q <= 1'b0;
      lvl_k_q   <= 1'b0;
    end else begin
      state_q   <= state_d;
      src_ext_q <= src_ext_d;
      lvl_k_q   <= lvl_k_d;
    end
  end

  assign state_o     = state_q;
  assign path_hs_o   = in_hs;
  assign resync_en_o = in_hs || (state_q == ST_TEST);
  assign drive_int_o = (state_q == ST_TEST) && src_ext_q;
  assign drive_ext_o = (state_q == ST_TEST) && !src_ext_q;
  assign drive_k_o   = (state_q == ST_TEST) && lvl_k_q;
endmodule

// File: rtl/usb_lsp_ctrl_chk.sv
module usb_lsp_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       en_i,
  input logic [1:0] int_line_i,
  input logic [1:0] ext_line_i,
  input logic       path_hs_o,
  input logic       resync_en_o,
  input logic       drive_int_o,
  input logic       drive_ext_o,
  input logic       drive_k_o,
  input logic [2:0] state_o
);
  // R7
  disc_on_disable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (state_o == 3'd0) && !path_hs_o && !resync_en_o && !drive_int_o && !drive_ext_o);

  // R2
  fs_to_chirp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && state_o == 3'd1 && int_line_i == 2'd2) |=> (state_o == 3'd2));

  // R3
  chirp_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && state_o == 3'd2 && int_line_i == 2'd0) |=>
      ((state_o == 3'd3 && path_hs_o && resync_en_o) || (state_o == 3'd1 && !path_hs_o)));

  // R5
  hs_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && state_o == 3'd3 && !(int_line_i == 2'd0 && ext_line_i == 2'd0)) |=>
      (state_o != 3'd1));

  // R9
  test_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && state_o == 3'd4) |=>
      (state_o == 3'd4 && $stable(drive_int_o) && $stable(drive_ext_o) && $stable(drive_k_o)));

  // R8
  one_drive_side_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({drive_int_o, drive_ext_o}));
endmodule

bind usb_lsp_ctrl usb_lsp_ctrl_chk u_chk (.*);

// File: tb/usb_lsp_ctrl_tb.sv
module usb_lsp_ctrl_tb;
  localparam int unsigned SE0_N  = 40;
  localparam int unsigned TEST_N = 20;
  localparam int unsigned PAIRS  = 3;
  localparam logic [1:0] SE0 = 2'd0, LJ = 2'd1, LK = 2'd2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b1;
  logic [1:0] il = LJ, el = LJ;
  logic       path_hs, resync_en, drv_int, drv_ext, drv_k;
  logic [2:0] st;

  typedef struct {
    string      tag;
    logic [2:0] st;
    logic       hs, rs, di, de, dk;
  } exp_t;

  exp_t exp_q[$];
  int   total = 0;
  int   bad   = 0;
  int   cyc   = 0;

  always #2 clk = ~clk;

  usb_lsp_ctrl #(.SE0_CYC(SE0_N), .TEST_CYC(TEST_N), .MIN_PAIRS(PAIRS)) u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .en_i        (en),
    .int_line_i  (il),
    .ext_line_i  (el),
    .path_hs_o   (path_hs),
    .resync_en_o (resync_en),
    .drive_int_o (drv_int),
    .drive_ext_o (drv_ext),
    .drive_k_o   (drv_k),
    .state_o     (st)
  );

  // monitor: compares queued expectations away from the active edge
  always @(negedge clk) begin
    while (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      total++;
      if ({st, path_hs, resync_en, drv_int, drv_ext, drv_k} !==
          {e.st, e.hs, e.rs, e.di, e.de, e.dk}) begin
        bad++;
        $display("FAIL %s: st/hs/rs/di/de/dk act=%0d/%b/%b/%b/%b/%b exp=%0d/%b/%b/%b/%b/%b",
                 e.tag, st, path_hs, resync_en, drv_int, drv_ext, drv_k,
                 e.st, e.hs, e.rs, e.di, e.de, e.dk);
      end
    end
  end

  task automatic apply(input logic [1:0] i, input logic [1:0] x, input logic e);
    @(negedge clk);
    il = i; el = x; en = e;
  endtask

  task automatic hold(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic expect_out(input string tag, input logic [2:0] s, input logic hs,
                            input logic rs, input logic di, input logic de, input logic dk);
    exp_t e;
    e.tag = tag; e.st = s; e.hs = hs; e.rs = rs; e.di = di; e.de = de; e.dk = dk;
    exp_q.push_back(e);
  endtask

  // host chirp train of n K-J pairs, then end-of-chirp SE0
  task automatic chirp(input int n);
    for (int i = 0; i < n; i++) begin
      apply(LK, SE0, 1'b1); hold(1);
      apply(LJ, SE0, 1'b1); hold(1);
    end
    apply(SE0, SE0, 1'b1); hold(1);
  endtask

  initial begin
    hold(3);
    @(negedge clk) rst_n = 1'b1;
    apply(LJ, LJ, 1'b1); hold(1);
    expect_out("R1 reset state", 3'd1, 0, 0, 0, 0, 0);

    apply(LK, LJ, 1'b1); hold(1);
    expect_out("R2 K enters chirp", 3'd2, 0, 0, 0, 0, 0);
    apply(LJ, LJ, 1'b1); hold(1);
    apply(LK, LJ, 1'b1); hold(1);
    apply(LJ, LJ, 1'b1); hold(1);
    expect_out("R2 chirp in progress", 3'd2, 0, 0, 0, 0, 0);
    apply(SE0, SE0, 1'b1); hold(1);
    expect_out("R4 short chirp stays bypass", 3'd1, 0, 0, 0, 0, 0);

    chirp(PAIRS);
    expect_out("R3 valid chirp enters hs", 3'd3, 1, 1, 0, 0, 0);

    hold(SE0_N - 1);
    expect_out("R5 one short of window", 3'd3, 1, 1, 0, 0, 0);
    apply(LJ, SE0, 1'b1); hold(1);
    expect_out("R5 J breaks run", 3'd3, 1, 1, 0, 0, 0);
    apply(SE0, SE0, 1'b1); hold(SE0_N - 1);
    expect_out("R5 restarted run short", 3'd3, 1, 1, 0, 0, 0);
    hold(1);
    expect_out("R5 long SE0 falls back", 3'd1, 0, 0, 0, 0, 0);

    chirp(PAIRS + 1);
    expect_out("R6 re-chirp returns hs", 3'd3, 1, 1, 0, 0, 0);

    apply(SE0, LK, 1'b1); hold(TEST_N);
    expect_out("R8 test window not reached", 3'd3, 1, 1, 0, 0, 0);
    hold(1);
    expect_out("R8 ext test K forwarded to int", 3'd4, 0, 1, 1, 0, 1);
    apply(LJ, LK, 1'b1); hold(1);
    apply(LK, LJ, 1'b1); hold(5);
    expect_out("R9 activity ignored", 3'd4, 0, 1, 1, 0, 1);
    apply(SE0, SE0, 1'b1); hold(SE0_N + 10);
    expect_out("R9 long SE0 ignored", 3'd4, 0, 1, 1, 0, 1);

    apply(SE0, SE0, 1'b0); hold(1);
    expect_out("R7 enable low disconnects", 3'd0, 0, 0, 0, 0, 0);
    apply(LK, SE0, 1'b0); hold(3);
    expect_out("R7 lines ignored when disabled", 3'd0, 0, 0, 0, 0, 0);
    apply(LJ, LJ, 1'b1); hold(1);
    expect_out("R7 enable high to bypass", 3'd1, 0, 0, 0, 0, 0);

    chirp(PAIRS);
    expect_out("R3 hs again", 3'd3, 1, 1, 0, 0, 0);
    apply(LJ, SE0, 1'b1); hold(TEST_N + 1);
    expect_out("R8 int test J forwarded to ext", 3'd4, 0, 1, 0, 1, 0);
    @(negedge clk) rst_n = 1'b0;
    hold(2);
    @(negedge clk) rst_n = 1'b1;
    expect_out("R9 reset clears test mode", 3'd1, 0, 0, 0, 0, 0);
    hold(1);

    chirp(PAIRS);
    expect_out("R3 hs before disable", 3'd3, 1, 1, 0, 0, 0);
    apply(SE0, SE0, 1'b0); hold(1);
    expect_out("R7 disable from hs", 3'd0, 0, 0, 0, 0, 0);

    hold(2);
    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      total++;
      bad++;
      $display("FAIL watchdog: act=%0d cycles exp=completion", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule